// File: doc/BRIEF.md
# Sidetone Control Register Block with Coefficient Loader

This block is the software-facing control plane of an audio sidetone path. A 32-bit register port (address, write data, write strobe, read strobe, registered read data) reaches a fixed revision word, a clock auto-idle control, a small interrupt status/enable pair, a packed two-channel gain word and a control word. The control word switches the sidetone on, arms coefficient loading and reports when loading has finished.

Filter coefficients go into a 128-entry store of signed 16-bit words through one data register. While the load-arm bit is set, every write to that register stores its low 16 bits at an internal pointer and advances it. After the last slot is filled the block reports completion and drops any further data writes. Clearing the arm bit and setting it again starts a new load at slot 0. The filter that uses these values sits outside. It reads coefficients through an index/data side port and takes both gains and the enable from dedicated outputs.

The loader is a three-state machine. **LD_IDLE** means arming is off and the pointer is held at 0. **LD_FILL** means arming is on and writes are being taken. **LD_FULL** means every slot is written and further writes are dropped. The transitions are: *arm* (LD_IDLE to LD_FILL, or straight to LD_FULL if that first write fills the last slot), *fill* (LD_FILL to LD_FULL on the write to the last slot), *disarm-early* (LD_FILL to LD_IDLE) and *disarm* (LD_FULL to LD_IDLE). The two disarm transitions happen when the arm bit reads 0.

Top module: `sidetone_ctrl`

## Requirements
- R1: After reset every register reads 0, with two exceptions: auto-idle reads 1 (so `idle_req`=1), and the revision returns `REV_VALUE`. All coefficient slots hold 0.
- R2: A read returns data one cycle after the read strobe. The offsets are revision 0x00, system config 0x10, IRQ status 0x18, IRQ enable 0x1C, gain 0x24, coefficient data 0x28 and control 0x2C. Any other offset, and the coefficient data offset, read as 0.
- R3: The revision register ignores writes.
- R4: The gain register holds channel 0 in bits 15:0 and channel 1 in bits 31:16. These fields drive `gain_ch0` and `gain_ch1`.
- R5: Control bit 0 drives `tone_en`. System config bit 0 (auto-idle) drives `idle_req`. Only these bits, plus control bit 1, are stored.
- R6: While control bit 1 (load arm) is set, each write to 0x28 stores bits 15:0 into the slot at the pointer. The pointer starts at 0 and counts up by one per write.
- R7: Control bit 2 (done, read-only) reads 0 until exactly 128 coefficient writes have been taken. It reads 1 from the cycle after the 128th.
- R8: Coefficient writes have no effect while load arm is 0, and none once all 128 slots are written.
- R9: Clearing load arm clears done at once. Setting it again restarts the pointer at slot 0, and writing 1 to an arm bit that is already set does not restart.
- R10: IRQ status bits are set by `irq_event` and cleared by writing 1 to them; a set event wins over a clear in the same cycle. IRQ enable is a plain read/write field of `IRQ_W` bits.
- R11: `coef_rd_data` shows the slot chosen by `coef_rd_idx` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_event | input | IRQ_W | Per-bit interrupt set pulses |
| coef_rd_idx | input | IDX_W | Coefficient slot to look at |
| coef_rd_data | output | COEF_W | Coefficient at `coef_rd_idx` |
| gain_ch0 | output | GAIN_W | Channel 0 gain |
| gain_ch1 | output | GAIN_W | Channel 1 gain |
| tone_en | output | 1 | Sidetone enable |
| idle_req | output | 1 | Clock auto-idle request |

## Verification
The bench uses the default parameters: 128 taps, 16-bit coefficients and gains, 8-bit addresses and 4 interrupt bits. These sizes are small enough to write and read back every coefficient slot through the side port across two complete loads with different arithmetic patterns. They also let the bench read all 256 byte offsets against a model of the register file. With the real depth, the done flag can be probed exactly at 127 and 128 writes. A load can be aborted part-way and restarted, and the writes that land on a full store can be shown to change nothing.

// File: rtl/sidetone_pkg.sv
package sidetone_pkg;
    localparam logic [7:0] OFS_REV      = 8'h00;
    localparam logic [7:0] OFS_SYSCFG   = 8'h10;
    localparam logic [7:0] OFS_IRQ_STAT = 8'h18;
    localparam logic [7:0] OFS_IRQ_EN   = 8'h1C;
    localparam logic [7:0] OFS_GAIN     = 8'h24;
    localparam logic [7:0] OFS_COEF     = 8'h28;
    localparam logic [7:0] OFS_CTRL     = 8'h2C;

    localparam int CTRL_TONE_BIT = 0;
    localparam int CTRL_ARM_BIT  = 1;
    localparam int CTRL_DONE_BIT = 2;

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_FILL = 2'd1,
        LD_FULL = 2'd2
    } load_state_e;
endpackage

// File: rtl/st_coef_mem.sv
module st_coef_mem #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] slot_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (wr_en) begin
            slot_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/st_coef_loader.sv
module st_coef_loader
    import sidetone_pkg::*;
#(
    parameter int NUM_TAPS = 128,
    localparam int IDX_W = $clog2(NUM_TAPS),
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TAPS - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             coef_wr,
    output logic             mem_we,
    output logic [IDX_W-1:0] mem_idx,
    output logic             load_done
);
    load_state_e      state_q, state_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic             last_wr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // Outputs
    always_comb begin
        mem_idx   = ptr_q;
        mem_we    = 1'b0;
        load_done = 1'b0;
        unique case (state_q)
            LD_IDLE: mem_we = load_en && coef_wr;
            LD_FILL: mem_we = load_en && coef_wr;
            LD_FULL: load_done = load_en;
            default: ;
        endcase
    end

    assign last_wr = mem_we && (ptr_q == LAST_IDX);

    // Next state
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            LD_IDLE: begin
                ptr_d = '0;
                if (load_en) begin
                    state_d = last_wr ? LD_FULL : LD_FILL;
                    if (mem_we && !last_wr) ptr_d = IDX_W'(1);
                end
            end
            LD_FILL: begin
                if (!load_en) begin
                    state_d = LD_IDLE;
                    ptr_d   = '0;
                end else if (last_wr) begin
                    state_d = LD_FULL;
                end else if (mem_we) begin
                    ptr_d = ptr_q + IDX_W'(1);
                end
            end
            LD_FULL: begin
                if (!load_en) begin
                    state_d = LD_IDLE;
                    ptr_d   = '0;
                end
            end
            default: begin
                state_d = LD_IDLE;
                ptr_d   = '0;
            end
        endcase
    end

    p_last_sets_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_idx == LAST_IDX) |=> (state_q == LD_FULL));
    p_full_drops_writes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_FULL) |-> !mem_we);
    p_disarm_clears_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(load_en) |-> !load_done);
    p_arm_starts_at_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_en) |-> (mem_idx == '0));
endmodule

// File: rtl/sidetone_ctrl.sv
module sidetone_ctrl
    import sidetone_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          NUM_TAPS  = 128,
    parameter int          COEF_W    = 16,
    parameter int          GAIN_W    = 16,
    parameter int          IRQ_W     = 4,
    parameter logic [31:0] REV_VALUE = 32'h0000_0102,
    localparam int IDX_W = $clog2(NUM_TAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic [IRQ_W-1:0]  irq_event,
    input  logic [IDX_W-1:0]  coef_rd_idx,
    output logic [COEF_W-1:0] coef_rd_data,
    output logic [GAIN_W-1:0] gain_ch0,
    output logic [GAIN_W-1:0] gain_ch1,
    output logic              tone_en,
    output logic              idle_req
);
    localparam logic [ADDR_W-1:0] A_REV  = ADDR_W'(OFS_REV);
    localparam logic [ADDR_W-1:0] A_SYS  = ADDR_W'(OFS_SYSCFG);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_IRQ_STAT);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFS_IRQ_EN);
    localparam logic [ADDR_W-1:0] A_GAIN = ADDR_W'(OFS_GAIN);
    localparam logic [ADDR_W-1:0] A_COEF = ADDR_W'(OFS_COEF);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

    logic                auto_idle_q;
    logic [IRQ_W-1:0]    irq_stat_q, irq_en_q, stat_clr;
    logic [2*GAIN_W-1:0] gain_q;
    logic                tone_q, arm_q;
    logic                mem_we, load_done;
    logic [IDX_W-1:0]    mem_idx;
    logic [31:0]         rd_mux;

    wire wr_sys  = bus_wr && (bus_addr == A_SYS);
    wire wr_stat = bus_wr && (bus_addr == A_STAT);
    wire wr_ien  = bus_wr && (bus_addr == A_IEN);
    wire wr_gain = bus_wr && (bus_addr == A_GAIN);
    wire wr_coef = bus_wr && (bus_addr == A_COEF);
    wire wr_ctrl = bus_wr && (bus_addr == A_CTRL);

    assign stat_clr = wr_stat ? bus_wdata[IRQ_W-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_idle_q <= 1'b1;
            irq_stat_q  <= '0;
            irq_en_q    <= '0;
            gain_q      <= '0;
            tone_q      <= 1'b0;
            arm_q       <= 1'b0;
        end else begin
            irq_stat_q <= (irq_stat_q & ~stat_clr) | irq_event;
            if (wr_sys)  auto_idle_q <= bus_wdata[0];
            if (wr_ien)  irq_en_q    <= bus_wdata[IRQ_W-1:0];
            if (wr_gain) gain_q      <= bus_wdata[2*GAIN_W-1:0];
            if (wr_ctrl) begin
                tone_q <= bus_wdata[CTRL_TONE_BIT];
                arm_q  <= bus_wdata[CTRL_ARM_BIT];
            end
        end
    end

    st_coef_loader #(.NUM_TAPS(NUM_TAPS)) u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (arm_q),
        .coef_wr   (wr_coef),
        .mem_we    (mem_we),
        .mem_idx   (mem_idx),
        .load_done (load_done)
    );

    st_coef_mem #(.DEPTH(NUM_TAPS), .WIDTH(COEF_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mem_we),
        .wr_idx  (mem_idx),
        .wr_data (bus_wdata[COEF_W-1:0]),
        .rd_idx  (coef_rd_idx),
        .rd_data (coef_rd_data)
    );

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            A_REV:  rd_mux = REV_VALUE;
            A_SYS:  rd_mux[0] = auto_idle_q;
            A_STAT: rd_mux[IRQ_W-1:0] = irq_stat_q;
            A_IEN:  rd_mux[IRQ_W-1:0] = irq_en_q;
            A_GAIN: rd_mux[2*GAIN_W-1:0] = gain_q;
            A_CTRL: begin
                rd_mux[CTRL_TONE_BIT] = tone_q;
                rd_mux[CTRL_ARM_BIT]  = arm_q;
                rd_mux[CTRL_DONE_BIT] = load_done;
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
        else             bus_rdata <= '0;
    end

    assign gain_ch0 = gain_q[GAIN_W-1:0];
    assign gain_ch1 = gain_q[2*GAIN_W-1:GAIN_W];
    assign tone_en  = tone_q;
    assign idle_req = auto_idle_q;

    p_rev_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_REV) |=> (bus_rdata == REV_VALUE));
    p_gain_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_gain |=> (gain_ch0 == $past(bus_wdata[GAIN_W-1:0])) &&
                    (gain_ch1 == $past(bus_wdata[2*GAIN_W-1:GAIN_W])));
    p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && irq_event == '0) |=>
            ((irq_stat_q & $past(bus_wdata[IRQ_W-1:0])) == '0));
    p_event_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_event != '0) |=> ((irq_stat_q & $past(irq_event)) == $past(irq_event)));
    p_done_needs_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> arm_q);
endmodule

// File: tb/sidetone_ctrl_test.sv
`timescale 1ns/1ps
module sidetone_ctrl_test;
    localparam int          ADDR_W = 8;
    localparam int          TAPS   = 128;
    localparam int          IDX_W  = 7;
    localparam logic [31:0] REV    = 32'h0000_0102;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0]       bus_rdata;
    logic [3:0]        irq_event = '0;
    logic [IDX_W-1:0]  coef_rd_idx = '0;
    logic [15:0]       coef_rd_data, gain_ch0, gain_ch1;
    logic              tone_en, idle_req;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sidetone_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .irq_event(irq_event), .coef_rd_idx(coef_rd_idx),
        .coef_rd_data(coef_rd_data), .gain_ch0(gain_ch0), .gain_ch1(gain_ch1),
        .tone_en(tone_en), .idle_req(idle_req)
    );

    function automatic logic [15:0] pat(int i, int k);
        return 16'((i * (2731 + 2 * k)) + 16'h1357 * (k + 1));
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic slot(int i, logic [15:0] exp, string req);
        coef_rd_idx = IDX_W'(i);
        #1;
        chk(req, {16'h0, coef_rd_data}, {16'h0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, v); chk("R1 rev", v, REV);
        rd(8'h10, v); chk("R1 syscfg", v, 32'h1);
        rd(8'h18, v); chk("R1 irq stat", v, 0);
        rd(8'h1C, v); chk("R1 irq en", v, 0);
        rd(8'h24, v); chk("R1 gain", v, 0);
        rd(8'h2C, v); chk("R1 ctrl", v, 0);
        chk("R1 idle_req", {31'h0, idle_req}, 1);
        chk("R1 tone_en", {31'h0, tone_en}, 0);
        bad = 0;
        for (int i = 0; i < TAPS; i++) begin
            coef_rd_idx = IDX_W'(i); #1;
            if (coef_rd_data !== 16'h0) bad++;
        end
        chk("R1 coef slots zero", bad, 0);

        // R3 revision ignores writes
        wr(8'h00, 32'hDEAD_BEEF);
        rd(8'h00, v); chk("R3 rev after write", v, REV);

        // R4 gains
        wr(8'h24, 32'h8001_7FFE);
        chk("R4 gain_ch0", {16'h0, gain_ch0}, 32'h7FFE);
        chk("R4 gain_ch1", {16'h0, gain_ch1}, 32'h8001);
        rd(8'h24, v); chk("R4 gain readback", v, 32'h8001_7FFE);

        // R5 enable and auto-idle
        wr(8'h2C, 32'hFFFF_FFF9);
        chk("R5 tone_en on", {31'h0, tone_en}, 1);
        rd(8'h2C, v); chk("R5 ctrl stored bits", v, 32'h1);
        wr(8'h10, 32'hFFFF_FFFE);
        chk("R5 idle_req off", {31'h0, idle_req}, 0);
        rd(8'h10, v); chk("R5 syscfg", v, 0);

        // R10 interrupts
        @(negedge clk); irq_event = 4'b1010;
        @(negedge clk); irq_event = 4'b0000;
        rd(8'h18, v); chk("R10 stat set", v, 32'hA);
        wr(8'h18, 32'h2);
        rd(8'h18, v); chk("R10 w1c one bit", v, 32'h8);
        wr(8'h18, 32'h0);
        rd(8'h18, v); chk("R10 write 0 keeps", v, 32'h8);
        @(negedge clk);
        bus_addr = 8'h18; bus_wdata = 32'hF; bus_wr = 1'b1; irq_event = 4'b0001;
        @(negedge clk);
        bus_wr = 1'b0; irq_event = 4'b0000;
        rd(8'h18, v); chk("R10 set beats clear", v, 32'h1);
        wr(8'h1C, 32'hFFFF_FFF5);
        rd(8'h1C, v); chk("R10 irq en", v, 32'h5);

        // R2 sweep every byte offset against the model
        bad = 0;
        for (int a = 0; a < 256; a++) begin
            logic [31:0] e;
            case (a)
                8'h00: e = REV;
                8'h10: e = 32'h0;
                8'h18: e = 32'h1;
                8'h1C: e = 32'h5;
                8'h24: e = 32'h8001_7FFE;
                8'h2C: e = 32'h1;
                default: e = 32'h0;
            endcase
            rd(8'(a), v);
            if (v !== e) begin
                bad++;
                $display("FAIL R2 offset %h actual=%h expected=%h", a, v, e);
            end
        end
        n_chk++; if (bad != 0) n_err++;
        wr(8'h10, 32'h1);

        // R8 coefficient write while disarmed
        wr(8'h28, 32'h0000_ABCD);
        slot(0, 16'h0, "R8 disarmed write ignored");

        // R6/R7 full load
        wr(8'h2C, 32'h3);
        for (int i = 0; i < TAPS; i++) begin
            wr(8'h28, {~16'(i), pat(i, 0)});
            if (i == TAPS - 2) begin
                rd(8'h2C, v); chk("R7 done after 127 writes", v, 32'h3);
            end
        end
        rd(8'h2C, v); chk("R7 done after 128 writes", v, 32'h7);
        bad = 0;
        for (int i = 0; i < TAPS; i++) begin
            coef_rd_idx = IDX_W'(i); #1;
            if (coef_rd_data !== pat(i, 0)) bad++;
        end
        chk("R6 R11 all slots pattern 0", bad, 0);

        // R8 writes past full
        wr(8'h28, 32'h1111);
        slot(0, pat(0, 0), "R8 past-full slot 0");
        slot(127, pat(127, 0), "R8 past-full slot 127");
        rd(8'h2C, v); chk("R8 still done", v, 32'h7);
        wr(8'h2C, 32'h7);
        wr(8'h28, 32'h1212);
        slot(0, pat(0, 0), "R9 re-arm while set no restart");

        // R9 disarm clears done
        wr(8'h2C, 32'h1);
        rd(8'h2C, v); chk("R9 done cleared", v, 32'h1);
        wr(8'h28, 32'h2222);
        slot(0, pat(0, 0), "R8 disarmed after load");

        // R9 restart, abort partway, restart again
        wr(8'h2C, 32'h3);
        rd(8'h2C, v); chk("R9 re-armed not done", v, 32'h3);
        wr(8'h28, 32'h4444);
        slot(0, 16'h4444, "R9 restart at slot 0");
        slot(1, pat(1, 0), "R9 slot 1 untouched");
        for (int i = 1; i < 6; i++) wr(8'h28, 32'(pat(i, 2)));
        wr(8'h2C, 32'h1);
        wr(8'h2C, 32'h3);
        for (int i = 0; i < TAPS; i++) begin
            wr(8'h28, {16'hA5A5, pat(i, 1)});
            if (i == 0) slot(1, pat(1, 2), "R9 slot 1 from aborted load");
            if (i == TAPS - 2) begin
                rd(8'h2C, v); chk("R7 reload 127", v, 32'h3);
            end
        end
        rd(8'h2C, v); chk("R7 reload 128", v, 32'h7);
        bad = 0;
        for (int i = 0; i < TAPS; i++) begin
            coef_rd_idx = IDX_W'(i); #1;
            if (coef_rd_data !== pat(i, 1)) bad++;
        end
        chk("R6 R11 all slots pattern 1", bad, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule